// File: doc/BRIEF.md
# USB Endpoint DMA Request Controller

This block runs the demand-mode handshake between the large, double-buffered data endpoint of a USB device and an external DMA controller that moves bytes to or from local memory. Software writes an enable bit, a direction bit, a single/burst selector and a burst length. The block then raises its request line whenever the endpoint buffer can supply or accept data. It turns each acknowledged strobe into a one-cycle byte pulse toward the buffer. It stops when it sees a qualified end-of-transfer, and reports that stop through a sticky interrupt flag.

The buffer side supplies three status flags. One says a complete received packet is waiting. One says the transmit buffer still has room. One marks the final byte of a received packet that is shorter than the buffer. All inputs are taken to be synchronous to `clk`. While the acknowledge is low, the block also tells the endpoint multiplexer to select the main endpoint. Normal CPU accesses to other endpoints can therefore fall between DMA cycles.

Top module: `epdma_req_ctrl`

## Requirements
- R1: After reset, and whenever `cfg_dma_en` is 0, `dreq` is 0. Clearing `cfg_dma_en` drops `dreq` in the same cycle. A rising edge of `cfg_dma_en` arms the block, and `dreq` can first be 1 on the third clock edge after that rise.
- R2: With `cfg_burst_mode`=0 (single-cycle), the first clock edge of an acknowledged byte strobe takes `dreq` low. Once the strobe is released and the buffer condition holds, `dreq` returns two edges after the release edge.
- R3: With `cfg_burst_mode`=1, `dreq` stays high through `cfg_burst_len` acknowledged bytes and drops on the edge that follows the last one. Each time `dreq` reasserts, the count is loaded again.
- R4: A `cfg_burst_len` of 0 behaves as a burst of one byte.
- R5: With `cfg_dir_rd`=1 (endpoint to memory), `dreq` is raised only while `buf_full` is 1. If `buf_full` falls while the request is waiting for a byte, `dreq` drops on the next edge.
- R6: With `cfg_dir_rd`=1, a byte acknowledged while `buf_short_last` is 1 drops `dreq`, whatever burst count remains. The next request carries a freshly loaded count.
- R7: With `cfg_dir_rd`=0 (memory to endpoint), `dreq` stays high while `buf_not_full` is 1, and drops on the next edge after it goes to 0.
- R8: `eot_n` takes effect only when it is low together with `dack_n` and with `rd_n` or `wr_n`. It then drops `dreq` on the next edge and sets `done_irq`. No further request is made until `cfg_dma_en` is cleared and set again.
- R9: `done_irq` is sticky. A one-cycle `irq_clr` clears it, and a new stop wins over a clear in the same cycle.
- R10: `ep_main_sel` is 1 exactly while `dack_n` is 0.
- R11: Each acknowledged strobe gives exactly one one-cycle pulse, and only while armed. The pulse is on `buf_rd_stb` for `rd_n` in read direction, or on `buf_wr_stb` for `wr_n` in write direction. A strobe of the other direction gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_dma_en | input | 1 | DMA enable bit written by the CPU |
| cfg_dir_rd | input | 1 | 1: endpoint to memory, 0: memory to endpoint |
| cfg_burst_mode | input | 1 | 1: burst, 0: single-cycle |
| cfg_burst_len | input | CNT_W | Bytes per burst (0 means 1) |
| irq_clr | input | 1 | CPU pulse that clears the completion flag |
| dack_n | input | 1 | DMA acknowledge, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| eot_n | input | 1 | End of transfer, active low |
| buf_full | input | 1 | A complete received packet is waiting |
| buf_not_full | input | 1 | Transmit buffer has room |
| buf_short_last | input | 1 | Current byte ends a short received packet |
| dreq | output | 1 | DMA request |
| ep_main_sel | output | 1 | Force selection of the main endpoint |
| done_irq | output | 1 | Sticky completion flag |
| buf_rd_stb | output | 1 | One-cycle pulse: take one byte from the buffer |
| buf_wr_stb | output | 1 | One-cycle pulse: place one byte into the buffer |

## Verification
The assertions assume that the DMA controller and the buffer behave as a demand-mode pair. A strobe is asserted only together with the acknowledge. Each strobe is released for at least one clock before the next one begins. The buffer flags and the configuration bits change only between strobes, never during one. The stimulus keeps to this: every byte is a two-cycle acknowledged strobe followed by an idle cycle, and every flag or configuration change is driven from the bench between bytes. The end-of-transfer input is also pulsed alone and with the acknowledge only, to show that those combinations are ignored.

// File: rtl/epdma_pkg.sv
package epdma_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_REQ  = 2'd2,
    ST_GAP  = 2'd3
  } req_state_t;

  // Decide whether an acknowledged byte ends the current request window.
  function automatic logic drop_after_byte(input logic burst_mode,
                                           input logic cnt_last,
                                           input logic short_drop);
    return (!burst_mode) || cnt_last || short_drop;
  endfunction

endpackage

// File: rtl/epdma_xfer_detect.sv
module epdma_xfer_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic dack_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic eot_n,
  input  logic dir_rd,
  input  logic active,
  output logic xfer_on,
  output logic byte_evt,
  output logic eot_qual,
  output logic rd_stb,
  output logic wr_stb,
  output logic ep_main_sel
);

  logic xfer_prev;
  logic dir_strobe;

  assign dir_strobe  = dir_rd ? !rd_n : !wr_n;
  assign xfer_on     = !dack_n && dir_strobe;
  assign byte_evt    = xfer_on && !xfer_prev;
  assign eot_qual    = !eot_n && !dack_n && (!rd_n || !wr_n);
  assign rd_stb      = byte_evt && active && dir_rd;
  assign wr_stb      = byte_evt && active && !dir_rd;
  assign ep_main_sel = !dack_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xfer_prev <= 1'b0;
    else        xfer_prev <= xfer_on;
  end

  assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_stb, wr_stb}));

  assert_strobe_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |=> !(rd_stb || wr_stb));

endmodule

// File: rtl/epdma_burst_ctr.sv
module epdma_burst_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] len,
  output logic             cnt_last
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] reload_val(input logic [CNT_W-1:0] l);
    return (l == '0) ? ONE : l;
  endfunction

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= reload_val(len);
    else if (dec)  cnt <= cnt - ONE;
  end

  assign cnt_last = (cnt == ONE);

  assert_dec_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt > ONE));

  assert_zero_len_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && len == '0) |=> cnt_last);

endmodule

// File: rtl/epdma_req_fsm.sv
module epdma_req_fsm
  import epdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic cond,
  input  logic byte_evt,
  input  logic xfer_on,
  input  logic burst_mode,
  input  logic cnt_last,
  input  logic short_drop,
  input  logic eot_hit,
  output logic req_on,
  output logic load_cnt,
  output logic dec_cnt
);

  req_state_t st, nxt;

  always_comb begin
    nxt      = st;
    load_cnt = 1'b0;
    dec_cnt  = 1'b0;
    if (!go || eot_hit) begin
      nxt = ST_OFF;
    end else begin
      case (st)
        ST_OFF:  nxt = ST_WAIT;
        ST_WAIT: if (cond) begin
                   nxt      = ST_REQ;
                   load_cnt = 1'b1;
                 end
        ST_REQ:  if (byte_evt) begin
                   if (drop_after_byte(burst_mode, cnt_last, short_drop)) nxt = ST_GAP;
                   else dec_cnt = 1'b1;
                 end else if (!cond) begin
                   nxt = ST_WAIT;
                 end
        ST_GAP:  if (!xfer_on) nxt = ST_WAIT;
        default: nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_OFF;
    else        st <= nxt;
  end

  assign req_on = (st == ST_REQ);

  assert_single_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REQ && byte_evt && !burst_mode) |=> (st != ST_REQ));

  assert_burst_end_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REQ && byte_evt && cnt_last) |=> (st != ST_REQ));

  assert_short_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REQ && byte_evt && short_drop) |=> (st != ST_REQ));

  assert_req_needs_buffer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_REQ) |-> $past(cond));

endmodule

// File: rtl/epdma_req_ctrl.sv
module epdma_req_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dma_en,
  input  logic             cfg_dir_rd,
  input  logic             cfg_burst_mode,
  input  logic [CNT_W-1:0] cfg_burst_len,
  input  logic             irq_clr,
  input  logic             dack_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             eot_n,
  input  logic             buf_full,
  input  logic             buf_not_full,
  input  logic             buf_short_last,
  output logic             dreq,
  output logic             ep_main_sel,
  output logic             done_irq,
  output logic             buf_rd_stb,
  output logic             buf_wr_stb
);

  logic en_q, run_q, irq_q;
  logic active, go, eot_hit, cond, short_drop;
  logic xfer_on, byte_evt, eot_qual;
  logic req_on, load_cnt, dec_cnt, cnt_last;

  assign active     = run_q && cfg_dma_en;
  assign go         = active;
  assign eot_hit    = eot_qual && active;
  assign cond       = cfg_dir_rd ? buf_full : buf_not_full;
  assign short_drop = cfg_dir_rd && buf_short_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      en_q <= cfg_dma_en;
      if (!cfg_dma_en || eot_hit) run_q <= 1'b0;
      else if (!en_q)             run_q <= 1'b1;
      if (eot_hit)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  epdma_xfer_detect u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .dack_n     (dack_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .eot_n      (eot_n),
    .dir_rd     (cfg_dir_rd),
    .active     (active),
    .xfer_on    (xfer_on),
    .byte_evt   (byte_evt),
    .eot_qual   (eot_qual),
    .rd_stb     (buf_rd_stb),
    .wr_stb     (buf_wr_stb),
    .ep_main_sel(ep_main_sel)
  );

  epdma_burst_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_cnt),
    .dec     (dec_cnt),
    .len     (cfg_burst_len),
    .cnt_last(cnt_last)
  );

  epdma_req_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .cond      (cond),
    .byte_evt  (byte_evt),
    .xfer_on   (xfer_on),
    .burst_mode(cfg_burst_mode),
    .cnt_last  (cnt_last),
    .short_drop(short_drop),
    .eot_hit   (eot_hit),
    .req_on    (req_on),
    .load_cnt  (load_cnt),
    .dec_cnt   (dec_cnt)
  );

  assign dreq     = req_on && cfg_dma_en;
  assign done_irq = irq_q;

  assert_no_req_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dma_en |-> !dreq);

  assert_eot_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eot_hit |=> (!dreq && done_irq));

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !irq_clr) |=> done_irq);

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !eot_hit) |=> !done_irq);

endmodule

// File: tb/epdma_req_ctrl_bench.sv
`timescale 1ns/1ps
module epdma_req_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dma_en = 1'b0, cfg_dir_rd = 1'b0, cfg_burst_mode = 1'b0;
  logic [7:0] cfg_burst_len = 8'd1;
  logic irq_clr = 1'b0;
  logic dack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, eot_n = 1'b1;
  logic buf_full = 1'b0, buf_not_full = 1'b1, buf_short_last = 1'b0;
  logic dreq, ep_main_sel, done_irq, buf_rd_stb, buf_wr_stb;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [1:0] expq[$];

  always #5 clk = ~clk;

  epdma_req_ctrl u_epdma_req_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_dma_en(cfg_dma_en), .cfg_dir_rd(cfg_dir_rd),
    .cfg_burst_mode(cfg_burst_mode), .cfg_burst_len(cfg_burst_len), .irq_clr(irq_clr),
    .dack_n(dack_n), .rd_n(rd_n), .wr_n(wr_n), .eot_n(eot_n),
    .buf_full(buf_full), .buf_not_full(buf_not_full), .buf_short_last(buf_short_last),
    .dreq(dreq), .ep_main_sel(ep_main_sel), .done_irq(done_irq),
    .buf_rd_stb(buf_rd_stb), .buf_wr_stb(buf_wr_stb)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every buffer pulse must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && (buf_rd_stb || buf_wr_stb)) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected pulse actual=%0d expected=0", {buf_rd_stb, buf_wr_stb});
      end else begin
        logic [1:0] e;
        e = expq.pop_front();
        if (e != {buf_rd_stb, buf_wr_stb}) begin
          fails++;
          $display("FAIL R11 pulse actual=%0d expected=%0d", {buf_rd_stb, buf_wr_stb}, e);
        end
      end
    end
  end

  // Driver: one acknowledged byte (two strobe cycles, one idle cycle).
  task automatic byte_xfer(input logic use_rd, input logic eot, input logic exp_stb,
                           output logic mid);
    if (exp_stb) expq.push_back({use_rd, ~use_rd});
    dack_n = 1'b0;
    if (use_rd) rd_n = 1'b0; else wr_n = 1'b0;
    if (eot) eot_n = 1'b0;
    tick();
    mid = dreq;
    tick();
    dack_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; eot_n = 1'b1;
    tick();
  endtask

  task automatic arm();
    cfg_dma_en = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic disarm();
    cfg_dma_en = 1'b0;
    tick(); tick();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic mid;
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1 reset dreq", dreq, 0);
    chk("R9 reset done_irq", done_irq, 0);
    chk("R10 reset ep_main_sel", ep_main_sel, 0);
    chk("R11 reset strobes", {buf_rd_stb, buf_wr_stb}, 0);

    // Single-cycle, write direction
    cfg_dma_en = 1'b1;
    tick(); tick();
    chk("R1 no request two edges after enable", dreq, 0);
    tick();
    chk("R1 request on third edge", dreq, 1);
    chk("R7 write request with room", dreq, 1);
    expq.push_back(2'b01);
    dack_n = 1'b0; wr_n = 1'b0;
    #1;
    chk("R10 main select with ack", ep_main_sel, 1);
    tick();
    chk("R2 single drops after ack", dreq, 0);
    tick();
    dack_n = 1'b1; wr_n = 1'b1;
    tick();
    chk("R2 still low after release edge", dreq, 0);
    tick();
    chk("R2 reasserts", dreq, 1);
    cfg_dma_en = 1'b0;
    #1;
    chk("R1 clear drops at once", dreq, 0);
    tick(); tick();

    // Burst of three, write direction
    cfg_burst_mode = 1'b1; cfg_burst_len = 8'd3;
    arm();
    for (int p = 0; p < 2; p++) begin
      byte_xfer(1'b0, 1'b0, 1'b1, mid);
      chk("R3 burst holds byte 1", dreq, 1);
      byte_xfer(1'b0, 1'b0, 1'b1, mid);
      chk("R3 burst holds byte 2", dreq, 1);
      byte_xfer(1'b0, 1'b0, 1'b1, mid);
      chk("R3 burst ends at count", mid, 0);
      tick();
      chk("R3 burst reasserts with reload", dreq, 1);
    end
    disarm();

    // Zero length
    cfg_burst_len = 8'd0;
    arm();
    byte_xfer(1'b0, 1'b0, 1'b1, mid);
    chk("R4 zero length acts as one", mid, 0);
    disarm();

    // Read direction, short packet
    cfg_dir_rd = 1'b1; cfg_burst_len = 8'd8; buf_full = 1'b0;
    arm();
    tick();
    chk("R5 no request without packet", dreq, 0);
    buf_full = 1'b1;
    tick();
    chk("R5 request with packet", dreq, 1);
    byte_xfer(1'b0, 1'b0, 1'b0, mid);
    chk("R11 wrong-direction strobe ignored", dreq, 1);
    byte_xfer(1'b1, 1'b0, 1'b1, mid);
    chk("R6 first byte holds", dreq, 1);
    buf_short_last = 1'b1;
    byte_xfer(1'b1, 1'b0, 1'b1, mid);
    buf_short_last = 1'b0;
    chk("R6 short last byte drops", mid, 0);
    tick();
    chk("R6 next packet reasserts", dreq, 1);
    for (int i = 0; i < 7; i++) begin
      byte_xfer(1'b1, 1'b0, 1'b1, mid);
      chk("R6 fresh count holds", dreq, 1);
    end
    byte_xfer(1'b1, 1'b0, 1'b1, mid);
    chk("R6 fresh count ends at eight", mid, 0);
    tick();
    chk("R5 request again", dreq, 1);
    buf_full = 1'b0;
    tick();
    chk("R5 packet gone drops request", dreq, 0);
    disarm();

    // Write direction, full buffer and end of transfer
    cfg_dir_rd = 1'b0; cfg_burst_len = 8'd4; buf_not_full = 1'b1;
    arm();
    chk("R7 request armed", dreq, 1);
    buf_not_full = 1'b0;
    tick();
    chk("R7 full buffer drops", dreq, 0);
    buf_not_full = 1'b1;
    tick();
    chk("R7 room again", dreq, 1);
    eot_n = 1'b0;
    tick(); tick();
    chk("R8 lone eot ignored dreq", dreq, 1);
    chk("R8 lone eot ignored irq", done_irq, 0);
    dack_n = 1'b0;
    tick();
    chk("R8 eot with ack only ignored", done_irq, 0);
    chk("R8 eot with ack only dreq", dreq, 1);
    chk("R10 select follows ack", ep_main_sel, 1);
    dack_n = 1'b1; eot_n = 1'b1;
    #1;
    chk("R10 select released", ep_main_sel, 0);
    tick();
    byte_xfer(1'b0, 1'b1, 1'b1, mid);
    chk("R8 qualified eot drops", mid, 0);
    chk("R8 qualified eot raises irq", done_irq, 1);
    tick(); tick(); tick();
    chk("R8 stays stopped", dreq, 0);
    chk("R9 flag sticky", done_irq, 1);
    irq_clr = 1'b1;
    tick();
    irq_clr = 1'b0;
    chk("R9 clear", done_irq, 0);
    tick();
    chk("R9 stays clear", done_irq, 0);

    // Disabled: no pulses
    disarm();
    byte_xfer(1'b0, 1'b0, 1'b0, mid);
    chk("R1 disabled no request", dreq, 0);
    tick();
    chk("R11 all expected pulses seen", expq.size(), 0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule